// File: doc/BRIEF.md
# Page-mode DRAM access controller

This block sits between a synchronous host and an asynchronous DRAM of one million 4-bit words whose address pins are shared between a row phase and a column phase. The host issues single reads and writes over a valid/ready port carrying a 20-bit word address and a 4-bit write value. The controller splits the address into a 10-bit row (upper bits) and a 10-bit column (lower bits). It sequences the active-low row strobe, column strobe, write enable and output enable, and returns read data with a one-cycle valid strobe.

Once a row is activated it stays open. Later requests to the same row are served by toggling only the column strobe. A request to another row first closes the open row and lets it precharge, then activates the new row. Every analog timing minimum is expressed as a whole number of clock cycles through parameters. A row is closed before it would exceed the maximum row-strobe low time. A separate refresh scheduler asks for the memory with a request line. The controller grants it only when the row is closed and precharged, and keeps its own strobes inactive while the grant is held.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: During and right after reset, ras_n, cas_n, we_n and oe_n are 1 (inactive), dq_oe is 0, rd_valid is 0 and ref_gnt is 0. With ref_req low, req_ready is 1 after reset.
- R2: On the cycle ras_n falls and for the following T_RAH-1 cycles (T_RAH cycles in all), dram_addr carries the row, which is req_addr[19:10].
- R3: For every cycle cas_n is low, dram_addr carries the column latched at the CAS fall, which is req_addr[9:0].
- R4: ras_n stays high for at least T_RP cycles before each fall, and stays low for at least T_RAS_MIN cycles before each rise.
- R5: cas_n falls only while ras_n is low, and at least T_RCD cycles after the most recent ras_n fall.
- R6: Consecutive requests to the open row reuse it without a new ras_n fall. Between two cas_n low pulses, cas_n stays high for at least T_CP cycles.
- R7: A request to a row other than the open one causes ras_n to rise, precharge, and fall once more with the new row.
- R8: Writes are early writes. we_n is 0 in the cycle before cas_n falls and stays 0 while cas_n is low. Meanwhile dq_oe is 1 with the write data, oe_n stays 1, and the data is stored at the latched row and column.
- R9: For a read, we_n stays 1 and oe_n is 0 while cas_n is low. dq_in is captured only once at least T_RAC cycles since the ras_n fall, T_CAC cycles since the cas_n fall, and T_AA cycles since the column reached dram_addr have all passed. Read data is returned in request order with rd_valid high for one cycle.
- R10: ras_n never stays low for more than T_RAS_MAX consecutive cycles. A long run of same-row requests is split by a close and reopen.
- R11: ref_gnt rises only when ras_n has been high for at least T_RP cycles. While ref_gnt is 1, ras_n and cas_n are 1 and req_ready is 0. The grant is held until ref_req falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request taken on this clock edge |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in upper 10 bits |
| req_wdata | input | 4 | Write value |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 4 | Returned read value |
| ref_req | input | 1 | Refresh scheduler wants the memory |
| ref_gnt | output | 1 | Memory closed, precharged and handed over |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_out | output | 4 | Data towards the memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 4 | Data from the memory |

## Verification
The embedded properties watch the pin relations every cycle: the row-to-column delay, precharge before activation, the ceiling on row-low time, write enable leading the column strobe, data drive only during a write strobe, the idle pins under a refresh grant, and read strobes following a read column cycle. Only the bench scenarios show that data lands at the right row and column and comes back in order. They also show that same-row bursts skip activation while row changes force one, and that a long burst is split under the row-low ceiling. These rely on a pin-level memory model that hands out valid data only once its access windows have expired.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,  // row closed, precharging or waiting
    ST_RCD,   // row strobe low, waiting before column phase
    ST_CSU,   // column address set up, strobe still high
    ST_CAS,   // column strobe low
    ST_OPEN,  // row open, column strobe high
    ST_REF    // memory handed to the refresh scheduler
  } fpm_state_e;
endpackage

// File: rtl/fpm_sat_cnt.sv
module fpm_sat_cnt #(
  parameter int W       = 8,
  parameter int MAX     = 255,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] C_MAX = W'(MAX);
  localparam logic [W-1:0] C_RST = W'(RST_VAL);

  logic [W-1:0] q_d;

  always_comb begin
    if (clr)             q_d = W'(1);
    else if (q != C_MAX) q_d = q + 1'b1;
    else                 q_d = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= C_RST;
    else        q <= q_d;
  end
endmodule

// File: rtl/fpm_rd_capture.sv
module fpm_rd_capture #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [DW-1:0] din,
  output logic          valid,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= cap_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data <= '0;
    else if (cap_en) data <= din;
  end
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int ROW_W     = 10,
  parameter int DATA_W    = 4,
  parameter int T_RP      = 6,
  parameter int T_RAS_MIN = 8,
  parameter int T_RAS_MAX = 12500,
  parameter int T_RCD     = 3,
  parameter int T_RAH     = 2,
  parameter int T_CAS     = 2,
  parameter int T_CP      = 2,
  parameter int T_CAC     = 2,
  parameter int T_AA      = 4,
  parameter int T_RAC     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ref_req,
  output logic              ref_gnt,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [((ROW_W > ADDR_W-ROW_W) ? ROW_W : ADDR_W-ROW_W)-1:0] dram_addr,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);
  localparam int COL_W = ADDR_W - ROW_W;
  localparam int MA_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int CNT_W = $clog2(T_RAS_MAX + 2);
  // worst-case row-low cycles one page access can still add
  localparam int L_ACC = 1 + T_CAS + T_CAC + T_AA + T_RAC;

  localparam logic [CNT_W-1:0] C_RP      = CNT_W'(T_RP);
  localparam logic [CNT_W-1:0] C_RAS_MIN = CNT_W'(T_RAS_MIN);
  localparam logic [CNT_W-1:0] C_RAS_MAX = CNT_W'(T_RAS_MAX);
  localparam logic [CNT_W-1:0] C_ROOM    = CNT_W'(T_RAS_MAX - L_ACC);
  localparam logic [CNT_W-1:0] C_RCD     = CNT_W'(T_RCD);
  localparam logic [CNT_W-1:0] C_RCD_M1  = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] C_RAH     = CNT_W'(T_RAH);
  localparam logic [CNT_W-1:0] C_CAS     = CNT_W'(T_CAS);
  localparam logic [CNT_W-1:0] C_CP_M1   = CNT_W'(T_CP - 1);
  localparam logic [CNT_W-1:0] C_CAC     = CNT_W'(T_CAC);
  localparam logic [CNT_W-1:0] C_AA_M1   = CNT_W'(T_AA - 1);
  localparam logic [CNT_W-1:0] C_RAC     = CNT_W'(T_RAC);

  fpm_state_e        state_q, state_d;
  logic              op_wr_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] wdata_q;
  logic [CNT_W-1:0]  hi_cnt, ras_cnt, st_cnt;
  logic              hit, rp_ok, ras_min_ok, page_room, rd_ok, cas_done;
  logic              accept, cap_en, ras_lo;

  // cycles with row strobe high, low, and cycles in the current state
  fpm_sat_cnt #(.W(CNT_W), .MAX(T_RP), .RST_VAL(T_RP)) u_hi_cnt (
    .clk(clk), .rst_n(rst_n),
    .clr(state_d == ST_IDLE && state_q != ST_IDLE), .q(hi_cnt));
  fpm_sat_cnt #(.W(CNT_W), .MAX(T_RAS_MAX + 1), .RST_VAL(0)) u_ras_cnt (
    .clk(clk), .rst_n(rst_n),
    .clr(state_q == ST_IDLE && state_d == ST_RCD), .q(ras_cnt));
  fpm_sat_cnt #(.W(CNT_W), .MAX(T_RAS_MAX + 1), .RST_VAL(0)) u_st_cnt (
    .clk(clk), .rst_n(rst_n),
    .clr(state_d != state_q), .q(st_cnt));

  always_comb begin
    hit        = (req_addr[ADDR_W-1 -: ROW_W] == row_q);
    rp_ok      = (hi_cnt >= C_RP);
    ras_min_ok = (ras_cnt >= C_RAS_MIN);
    page_room  = (ras_cnt < C_ROOM);
    rd_ok      = (st_cnt >= C_CAC) && (st_cnt >= C_AA_M1) && (ras_cnt >= C_RAC);
    cas_done   = (st_cnt >= C_CAS) && (op_wr_q || rd_ok);
    req_ready  = !ref_req &&
                 ((state_q == ST_IDLE && rp_ok) ||
                  (state_q == ST_OPEN && hit && st_cnt >= C_CP_M1 && page_room));
    accept     = req_valid && req_ready;
    cap_en     = (state_q == ST_CAS) && !op_wr_q && cas_done;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_req && rp_ok) state_d = ST_REF;
        else if (accept)      state_d = ST_RCD;
      end
      ST_RCD:  if (st_cnt >= C_RCD_M1) state_d = ST_CSU;
      ST_CSU:  state_d = ST_CAS;
      ST_CAS:  if (cas_done) state_d = ST_OPEN;
      ST_OPEN: begin
        if (accept) state_d = ST_CSU;
        else if (ras_min_ok && (ref_req || !page_room || (req_valid && !hit)))
          state_d = ST_IDLE;
      end
      ST_REF:  if (!ref_req) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_wr_q <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      op_wr_q <= req_wr;
      row_q   <= req_addr[ADDR_W-1 -: ROW_W];
      col_q   <= req_addr[COL_W-1:0];
      wdata_q <= req_wdata;
    end
  end

  fpm_rd_capture #(.DW(DATA_W)) u_rd_capture (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .din(dram_dq_in),
    .valid(rd_valid), .data(rd_data));

  // pin decode from the state register
  always_comb begin
    ras_lo      = !(state_q inside {ST_IDLE, ST_REF});
    dram_ras_n  = !ras_lo;
    dram_cas_n  = (state_q != ST_CAS);
    dram_we_n   = !(op_wr_q && (state_q inside {ST_CSU, ST_CAS}));
    dram_oe_n   = !(!op_wr_q && state_q == ST_CAS);
    dram_dq_oe  = op_wr_q && (state_q == ST_CAS);
    dram_dq_out = wdata_q;
    ref_gnt     = (state_q == ST_REF);
    if (!ras_lo || (state_q == ST_RCD && st_cnt <= C_RAH)) dram_addr = MA_W'(row_q);
    else                                                   dram_addr = MA_W'(col_q);
  end

  p_rp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> ($past(hi_cnt) >= C_RP));
  p_rcd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> (!dram_ras_n && ras_cnt > C_RCD));
  p_we_lead_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_we_n) |-> ($past(dram_we_n) == 1'b0));
  p_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dram_dq_oe |-> (dram_oe_n && !dram_we_n && !dram_cas_n));
  p_rd_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!dram_cas_n && dram_we_n));
  p_ras_ceiling_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> (ras_cnt <= C_RAS_MAX));
  p_gnt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (dram_ras_n && dram_cas_n && !req_ready));
endmodule

// File: tb/fpm_dram_ctrl_bench.sv
`timescale 1ns/1ps
module fpm_dram_ctrl_bench;
  localparam int B_RP = 6, B_RAS_MIN = 8, B_RAS_MAX = 60, B_RCD = 3, B_RAH = 2;
  localparam int B_CP = 2, B_CAC = 2, B_AA = 4, B_RAC = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_wr, req_ready, rd_valid, ref_req, ref_gnt;
  logic [19:0] req_addr;
  logic [3:0]  req_wdata, rd_data, dq_out, dq_in;
  logic ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [9:0] maddr;

  always #4 clk = ~clk;

  fpm_dram_ctrl #(.T_RAS_MAX(B_RAS_MAX)) u_fpm_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
    .dram_addr(maddr), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] dflt(input logic [19:0] a);
    return a[3:0] ^ a[13:10] ^ 4'h5;
  endfunction

  // pin-level memory model and host-side shadow
  logic [3:0] dmem [int unsigned];
  logic [3:0] smem [int unsigned];
  logic [3:0] exp_q [$];
  function automatic logic [3:0] rd_dmem(input logic [19:0] a);
    return dmem.exists(a) ? dmem[a] : dflt(a);
  endfunction
  function automatic logic [3:0] rd_smem(input logic [19:0] a);
    return smem.exists(a) ? smem[a] : dflt(a);
  endfunction

  int ras_hi = 100, ras_lo = 0, cas_hi = 100, cas_lo = 0, col_age = 0, ras_falls = 0;
  logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, p_gnt = 1'b0;
  logic [9:0] p_addr = '0, m_row = '0, m_col = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(ras_n && cas_n && we_n && oe_n && !dq_oe && !rd_valid && !ref_gnt, "R1",
          {ras_n, cas_n, we_n, oe_n, dq_oe, rd_valid, ref_gnt}, 7'b1111000);
    end else begin
      if (p_ras && !ras_n) begin
        chk(ras_hi >= B_RP, "R4", ras_hi, B_RP);
        m_row = maddr; ras_falls++; ras_lo = 1;
      end else if (!ras_n) ras_lo++;
      if (!p_ras && ras_n) begin
        chk(ras_lo >= B_RAS_MIN, "R4", ras_lo, B_RAS_MIN);
        ras_hi = 1;
      end else if (ras_n) ras_hi++;
      if (!ras_n && ras_lo <= B_RAH) chk(maddr == m_row, "R2", maddr, m_row);
      if (!ras_n) chk(ras_lo <= B_RAS_MAX, "R10", ras_lo, B_RAS_MAX);
      if (addr_changed()) col_age = 1; else col_age++;
      if (p_cas && !cas_n) begin
        chk(!ras_n && ras_lo - 1 >= B_RCD, "R5", ras_lo - 1, B_RCD);
        chk(cas_hi >= B_CP, "R6", cas_hi, B_CP);
        m_col = maddr; cas_lo = 1;
        if (!we_n) begin
          chk(!p_we, "R8", p_we, 0);
          chk(dq_oe, "R8", dq_oe, 1);
          dmem[{m_row, m_col}] = dq_out;
        end
      end else if (!cas_n) cas_lo++;
      if (!p_cas && cas_n) cas_hi = 1; else if (cas_n) cas_hi++;
      if (!cas_n) begin
        chk(maddr == m_col, "R3", maddr, m_col);
        if (!we_n) chk(oe_n && dq_oe, "R8", {oe_n, dq_oe}, 2'b11);
        else       chk(!oe_n && !dq_oe, "R9", {oe_n, dq_oe}, 2'b00);
        if (!p_cas) chk(we_n == p_we, "R8", we_n, p_we);
      end
      if (ref_gnt) chk(ras_n && cas_n && !req_ready, "R11", {ras_n, cas_n, req_ready}, 3'b110);
      if (ref_gnt && !p_gnt) chk(ras_hi >= B_RP, "R11", ras_hi, B_RP);
      if (req_valid && req_ready) begin
        if (req_wr) smem[req_addr] = req_wdata;
        else        exp_q.push_back(rd_smem(req_addr));
      end
      if (rd_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R9", rd_data, -1);
        else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R9", rd_data, e);
        end
      end
    end
    // model output: valid only after all three access windows have run out
    if (!cas_n && ras_lo >= B_RAC && cas_lo >= B_CAC && col_age >= B_AA)
      dq_in = rd_dmem({m_row, m_col});
    else
      dq_in = ~rd_dmem({m_row, m_col});
    p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_addr = maddr; p_gnt = ref_gnt;
  end

  function automatic bit addr_changed();
    return maddr != p_addr;
  endfunction

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
      summary();
    end
  end

  // call right after a rising edge; returns right after the accepting edge
  task automatic do_req(input logic wr, input logic [19:0] a, input logic [3:0] d);
    req_valid = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  initial begin
    int f0;
    bit seen;
    rst_n = 1'b0; req_valid = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0;
    ref_req = 1'b0; dq_in = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && cas_n && !rd_valid && !ref_gnt && req_ready, "R1",
        {ras_n, cas_n, rd_valid, ref_gnt, req_ready}, 5'b11001);
    @(posedge clk); #1;

    // same-row burst: one activation (R6, R8, R9)
    f0 = ras_falls;
    do_req(1'b1, {10'h155, 10'h001}, 4'h3);
    do_req(1'b1, {10'h155, 10'h002}, 4'hC);
    do_req(1'b1, {10'h155, 10'h003}, 4'h9);
    do_req(1'b0, {10'h155, 10'h003}, 4'h0);
    do_req(1'b0, {10'h155, 10'h001}, 4'h0);
    do_req(1'b0, {10'h155, 10'h002}, 4'h0);
    drain();
    chk(ras_falls - f0 == 1, "R6", ras_falls - f0, 1);

    // row change forces close and reopen (R7)
    f0 = ras_falls;
    do_req(1'b0, {10'h2AA, 10'h005}, 4'h0);
    do_req(1'b1, {10'h2AA, 10'h005}, 4'h6);
    do_req(1'b0, {10'h2AA, 10'h005}, 4'h0);
    drain();
    chk(ras_falls - f0 == 1, "R7", ras_falls - f0, 1);
    f0 = ras_falls;
    do_req(1'b0, {10'h155, 10'h002}, 4'h0);
    drain();
    chk(ras_falls - f0 == 1, "R7", ras_falls - f0, 1);

    // address extremes (R2, R3)
    do_req(1'b1, 20'hFFFFF, 4'hE);
    do_req(1'b1, 20'h00000, 4'h7);
    do_req(1'b0, 20'hFFFFF, 4'h0);
    do_req(1'b0, 20'h00000, 4'h0);
    do_req(1'b0, 20'h003FF, 4'h0);
    drain();

    // refresh handover with a host request waiting (R11)
    ref_req = 1'b1;
    req_valid = 1'b1; req_wr = 1'b0; req_addr = {10'h155, 10'h001};
    seen = 1'b0;
    for (int i = 0; i < 60 && !seen; i++) begin
      @(negedge clk);
      seen = ref_gnt;
    end
    chk(seen, "R11", seen, 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(ref_gnt && !req_ready, "R11", {ref_gnt, req_ready}, 2'b10);
    end
    @(posedge clk); #1 ref_req = 1'b0;
    do_req(1'b0, {10'h155, 10'h001}, 4'h0);
    drain();
    chk(!ref_gnt, "R11", ref_gnt, 0);

    // long same-row run must be split under the ceiling (R10)
    f0 = ras_falls;
    for (int i = 0; i < 30; i++) do_req(1'b0, {10'h155, 10'(i)}, 4'h0);
    drain();
    chk(ras_falls - f0 >= 2, "R10", ras_falls - f0, 2);

    // write then read at the same cell inside the page (R8)
    do_req(1'b1, {10'h155, 10'h010}, 4'hA);
    do_req(1'b0, {10'h155, 10'h010}, 4'h0);
    drain();
    repeat (5) @(posedge clk);
    chk(exp_q.size() == 0, "R9", exp_q.size(), 0);
    summary();
  end
endmodule